// File: doc/BRIEF.md
# Aligned Block DMA Sequencer

This block is the DMA engine behind one serial expansion channel. A channel controller hands it a start address, a byte length, a two-bit direction code and a one-cycle start pulse. The sequencer then moves data between system memory and the channel's byte shifter one 32-bit word at a time. It stops when the whole length has been moved and raises `done` for one cycle. The controller uses that pulse to clear its start bit and to set its transfer-complete status.

Addresses and lengths are forced to 32-byte granularity: the five low bits of both are ignored. Memory words are big-endian. The byte in bits [31:24] is the first byte on the serial side. The byte streams use valid/ready. A byte moves on a rising edge where both valid and ready are high. While valid is high and ready is low, the source holds its data unchanged. The memory request port follows the same rule: the sequencer holds `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` steady until `mem_ready` is seen. Read data is taken in the cycle of that handshake. None of the sequencer's outputs depends combinationally on its inputs.

Top module: `blkdma_seq`

## Requirements
- R1: While reset is low, and on the first cycle after it, `busy`, `done`, `mem_valid`, `tx_valid` and `rx_ready` are all 0.
- R2: A start pulse is accepted only when `dma_mode` is 1 and the sequencer is idle. A start with `dma_mode` 0 causes no busy, no done and no memory access. An accepted valid start drives `busy` high on the next cycle.
- R3: The first memory address of a transfer equals `base_addr` with bits [4:0] forced to zero.
- R4: The transfer moves exactly (`xfer_len` with bits [4:0] forced to zero) / 4 words.
- R5: Direction code 01 moves memory to serial. Each word read is sent on `tx_data` as four bytes: bits [31:24] first, then [23:16], [15:8] and [7:0].
- R6: Direction code 00 moves serial to memory. Four received bytes form one word, with the first received byte in bits [31:24]. A write request appears only after all four bytes of its word have been received.
- R7: Each memory access after the first in a transfer uses the previous address plus 4.
- R8: A start with direction 10 or 11, or with a masked length of zero, makes no memory access. It raises `done` in the cycle right after the start is sampled.
- R9: `done` is a single-cycle pulse after the final word completes, and `busy` is low in the following cycle.
- R10: While `mem_valid` or `tx_valid` waits without ready, that request and its address, direction and data stay unchanged.
- R11: A start pulse that arrives while the sequencer is busy, including the cycle in which `done` is high, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse from the channel controller |
| dma_mode | input | 1 | 1 selects DMA; 0 (immediate mode) makes this block ignore start |
| dir | input | 2 | 00 serial to memory, 01 memory to serial, 10/11 rejected |
| base_addr | input | AW | Start address; bits [4:0] ignored |
| xfer_len | input | LW | Length in bytes; bits [4:0] ignored |
| busy | output | 1 | High from an accepted start through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address of the request |
| mem_wdata | output | 32 | Write data, big-endian |
| mem_ready | input | 1 | Memory accepts the request; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Byte to the shift engine valid |
| tx_ready | input | 1 | Shift engine takes the byte |
| tx_data | output | 8 | Byte to the shift engine |
| rx_valid | input | 1 | Byte from the shift engine valid |
| rx_ready | output | 1 | Sequencer takes the byte |
| rx_data | input | 8 | Byte from the shift engine |

## Verification
Two events can fall in the same cycle. One is the completion pulse of a transfer. The other is a fresh start request from a controller that reacts to completion at once. The bench provokes this by raising `start` exactly in the cycle where it sees `done`. It also raises a start with a different direction in the middle of a busy transfer. The result is judged at the ports: `busy` must be low for the next two cycles, the number of memory accesses must equal that of the first transfer alone, and the first transfer's data must be intact. Memory and shifter ready signals are random every cycle, so the last byte's handshake and the next word request meet in many different alignments.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;
  localparam int unsigned WORD_BYTES = 4;

  typedef enum logic [1:0] {
    DIR_TO_MEM   = 2'b00,
    DIR_FROM_MEM = 2'b01,
    DIR_DUPLEX   = 2'b10,
    DIR_RSVD     = 2'b11
  } dma_dir_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_TX,
    ST_RX,
    ST_WR_REQ,
    ST_FIN
  } dma_state_e;
endpackage

// File: rtl/blkdma_addr_gen.sv
module blkdma_addr_gen #(
  parameter int unsigned AW        = 32,
  parameter int unsigned LW        = 24,
  parameter int unsigned BLK_BYTES = 32,
  parameter int unsigned STEP      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] base_i,
  input  logic [LW-1:0] len_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o,
  output logic          len_zero_o
);
  localparam logic [AW-1:0] A_MASK = ~AW'(BLK_BYTES - 1);
  localparam logic [LW-1:0] L_MASK = ~LW'(BLK_BYTES - 1);

  logic [AW-1:0] base_al;
  logic [LW-1:0] len_al;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] rem_q;

  assign base_al    = base_i & A_MASK;
  assign len_al     = len_i & L_MASK;
  assign len_zero_o = (len_al == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (load) begin
      addr_q <= base_al;
      rem_q  <= len_al;
    end else if (step) begin
      addr_q <= addr_q + AW'(STEP);
      rem_q  <= rem_q - LW'(STEP);
    end
  end

  assign addr_o = addr_q;
  assign last_o = (rem_q == LW'(STEP));
endmodule

// File: rtl/blkdma_unpack.sv
module blkdma_unpack #(
  parameter int unsigned NB = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [8*NB-1:0] word_i,
  output logic            tx_valid,
  input  logic            tx_ready,
  output logic [7:0]      tx_data,
  output logic            last_beat_o
);
  localparam int unsigned IW = (NB > 1) ? $clog2(NB) : 1;

  logic [8*NB-1:0] sh_q;
  logic [IW-1:0]   idx_q;
  logic            act_q;
  logic            fire;
  logic            last;

  assign fire        = act_q && tx_ready;
  assign last        = (idx_q == IW'(NB - 1));
  assign last_beat_o = fire && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
      act_q <= 1'b0;
    end else if (load) begin
      sh_q  <= word_i;
      idx_q <= '0;
      act_q <= 1'b1;
    end else if (fire) begin
      sh_q  <= sh_q << 8;
      idx_q <= last ? '0 : idx_q + 1'b1;
      if (last) act_q <= 1'b0;
    end
  end

  assign tx_valid = act_q;
  assign tx_data  = sh_q[8*NB-1 -: 8];
endmodule

// File: rtl/blkdma_pack.sv
module blkdma_pack #(
  parameter int unsigned NB = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            enable,
  input  logic            rx_valid,
  output logic            rx_ready,
  input  logic [7:0]      rx_data,
  output logic [8*NB-1:0] word_o,
  output logic            word_done_o
);
  localparam int unsigned IW = (NB > 1) ? $clog2(NB) : 1;

  logic [8*NB-1:0] sh_q;
  logic [IW-1:0]   idx_q;
  logic            fire;
  logic            last;

  assign rx_ready    = enable;
  assign fire        = enable && rx_valid;
  assign last        = (idx_q == IW'(NB - 1));
  assign word_done_o = fire && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (clear) begin
      idx_q <= '0;
    end else if (fire) begin
      sh_q  <= {sh_q[8*NB-9:0], rx_data};
      idx_q <= last ? '0 : idx_q + 1'b1;
    end
  end

  assign word_o = sh_q;
endmodule

// File: rtl/blkdma_seq.sv
module blkdma_seq
  import blkdma_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned LW        = 24,
  parameter int unsigned BLK_BYTES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dma_mode,
  input  logic [1:0]    dir,
  input  logic [AW-1:0] base_addr,
  input  logic [LW-1:0] xfer_len,
  output logic          busy,
  output logic          done,
  output logic          mem_valid,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ready,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [7:0]    rx_data
);
  localparam int unsigned DW = 8 * WORD_BYTES;

  dma_state_e state_q, state_d;
  logic accept, reject, load, step, mem_fire;
  logic last_word, len_zero, last_beat, word_done;
  logic [DW-1:0] packed_word;

  assign accept   = start && dma_mode && (state_q == ST_IDLE);
  assign reject   = dir[1] || len_zero;
  assign load     = accept && !reject;
  assign mem_fire = mem_valid && mem_ready;
  assign step     = ((state_q == ST_TX) && last_beat) ||
                    ((state_q == ST_WR_REQ) && mem_fire);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:
        if (accept) begin
          if (reject)                   state_d = ST_FIN;
          else if (dir == DIR_FROM_MEM) state_d = ST_RD_REQ;
          else                          state_d = ST_RX;
        end
      ST_RD_REQ: if (mem_fire) state_d = ST_TX;
      ST_TX:     if (last_beat) state_d = last_word ? ST_FIN : ST_RD_REQ;
      ST_RX:     if (word_done) state_d = ST_WR_REQ;
      ST_WR_REQ: if (mem_fire) state_d = last_word ? ST_FIN : ST_RX;
      ST_FIN:    state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  blkdma_addr_gen #(
    .AW(AW), .LW(LW), .BLK_BYTES(BLK_BYTES), .STEP(WORD_BYTES)
  ) u_agen (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .base_i(base_addr), .len_i(xfer_len),
    .addr_o(mem_addr), .last_o(last_word), .len_zero_o(len_zero)
  );

  blkdma_unpack #(.NB(WORD_BYTES)) u_unpack (
    .clk(clk), .rst_n(rst_n),
    .load((state_q == ST_RD_REQ) && mem_fire),
    .word_i(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .last_beat_o(last_beat)
  );

  blkdma_pack #(.NB(WORD_BYTES)) u_pack (
    .clk(clk), .rst_n(rst_n), .clear(load),
    .enable(state_q == ST_RX),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .word_o(packed_word), .word_done_o(word_done)
  );

  assign mem_valid = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
  assign mem_we    = (state_q == ST_WR_REQ);
  assign mem_wdata = packed_word;
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_FIN);
endmodule

// File: rtl/blkdma_seq_chk.sv
module blkdma_seq_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          dma_mode,
  input logic [1:0]    dir,
  input logic          busy,
  input logic          done,
  input logic          mem_valid,
  input logic          mem_we,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          rx_valid,
  input logic          rx_ready
);
  logic [2:0]    rx_cnt;
  logic          have_prev;
  logic [AW-1:0] prev_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_cnt    <= '0;
      have_prev <= 1'b0;
      prev_addr <= '0;
    end else begin
      if (mem_valid && mem_ready && mem_we) rx_cnt <= '0;
      else if (rx_valid && rx_ready)        rx_cnt <= rx_cnt + 3'd1;
      if (done) have_prev <= 1'b0;
      else if (mem_valid && mem_ready) begin
        have_prev <= 1'b1;
        prev_addr <= mem_addr;
      end
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!busy && !done && !mem_valid && !tx_valid && !rx_ready));

  p_immediate_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !dma_mode && !busy) |=> (!busy && !done));

  p_first_addr_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !have_prev) |-> (mem_addr[4:0] == 5'd0));

  p_full_word_before_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we) |-> (rx_cnt == 3'd4));

  p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && have_prev) |-> (mem_addr == prev_addr + AW'(4)));

  p_bad_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && dma_mode && !busy && dir[1]) |=> (done && !mem_valid));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

  p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  p_idle_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_valid && !tx_valid && !rx_ready));
endmodule

bind blkdma_seq blkdma_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .dma_mode(dma_mode), .dir(dir),
  .busy(busy), .done(done), .mem_valid(mem_valid), .mem_we(mem_we),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready)
);

// File: tb/sim_blkdma_seq.sv
module sim_blkdma_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int LW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          dma_mode = 1'b0;
  logic [1:0]    dir = 2'b00;
  logic [AW-1:0] base_addr = '0;
  logic [LW-1:0] xfer_len = '0;
  logic          busy, done;
  logic          mem_valid, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic          mem_ready = 1'b0;
  logic [31:0]   mem_rdata = '0;
  logic          tx_valid;
  logic          tx_ready = 1'b0;
  logic [7:0]    tx_data;
  logic          rx_valid = 1'b0;
  logic          rx_ready;
  logic [7:0]    rx_data = '0;

  int n_checks = 0;
  int n_errs   = 0;

  logic [31:0] bmem [0:1023];
  logic [7:0]  tx_buf [0:255];
  logic [7:0]  rx_buf [0:255];
  int tx_cnt = 0, rx_ptr = 0, rx_len = 0, acc_cnt = 0, wr_cnt = 0;
  logic [31:0] exp_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blkdma_seq #(.AW(AW), .LW(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dma_mode(dma_mode), .dir(dir),
    .base_addr(base_addr), .xfer_len(xfer_len), .busy(busy), .done(done),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] aligned(input logic [31:0] v);
    return v & ~32'h1F;
  endfunction

  // Memory, transmit sink and receive source; handshakes decided at negedge.
  initial begin
    forever begin
      @(negedge clk);
      tx_ready = ($urandom % 4) != 0;
      if (tx_valid && tx_ready) begin
        if (tx_cnt < 256) tx_buf[tx_cnt] = tx_data;
        tx_cnt++;
      end
      if (rx_ptr < rx_len) begin
        rx_valid = ($urandom % 4) != 0;
        rx_data  = rx_buf[rx_ptr];
      end else begin
        rx_valid = 1'b0;
      end
      if (rx_valid && rx_ready) rx_ptr++;
      mem_ready = ($urandom % 4) != 0;
      mem_rdata = bmem[mem_addr[11:2]];
      if (mem_valid && mem_ready) begin
        check(mem_addr == exp_addr, "R7 address sequence", mem_addr, exp_addr);
        exp_addr = exp_addr + 32'd4;
        if (mem_we) begin
          check(rx_ptr == 4 * (wr_cnt + 1), "R6 bytes before write",
                rx_ptr, 4 * (wr_cnt + 1));
          bmem[mem_addr[11:2]] = mem_wdata;
          wr_cnt++;
        end
        acc_cnt++;
      end
    end
  end

  task automatic run_xfer(input logic [1:0] d, input logic [31:0] base,
                          input logic [23:0] len, input bit poke);
    int n_words;
    bit bad;
    int cyc;
    int idx0;
    n_words = int'((len & ~24'h1F) / 4);
    bad = d[1] || (n_words == 0);
    exp_addr = aligned(base);
    idx0 = int'(aligned(base) >> 2);
    acc_cnt = 0; tx_cnt = 0; wr_cnt = 0; rx_ptr = 0;
    rx_len = (!bad && d == 2'b00) ? n_words * 4 : 0;
    for (int k = 0; k < rx_len; k++) rx_buf[k] = 8'($urandom);
    dir = d; base_addr = base; xfer_len = len; dma_mode = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (bad) begin
      check(done == 1'b1, "R8 immediate done", done, 1);
    end else begin
      check(busy && !done, "R2 busy after start", {busy, done}, 2'b10);
    end
    cyc = 0;
    while (!done && cyc < 20000) begin
      if (poke && cyc == 3) begin
        start = 1'b1; dir = ~d & 2'b01;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0; dir = d;
    check(done == 1'b1, "R9 done reached", done, 1);
    if (poke) start = 1'b1;          // start lands in the done cycle
    @(negedge clk);
    start = 1'b0;
    check(!done && !busy, "R9 single pulse, busy low", {done, busy}, 0);
    if (poke) begin
      @(negedge clk);
      check(!busy, "R11 start during busy/done ignored", busy, 0);
    end
    check(acc_cnt == (bad ? 0 : n_words), "R4 word count (R8 none if rejected)",
          acc_cnt, bad ? 0 : n_words);
    if (!bad && d == 2'b01) begin
      check(tx_cnt == 4 * n_words, "R5 byte count", tx_cnt, 4 * n_words);
      for (int k = 0; k < 4 * n_words && k < 256; k++) begin
        logic [31:0] w;
        logic [7:0] eb;
        w = bmem[(idx0 + k / 4) % 1024];
        eb = w[31 - 8 * (k % 4) -: 8];
        check(tx_buf[k] == eb, "R5 byte order", tx_buf[k], eb);
      end
    end
    if (!bad && d == 2'b00) begin
      for (int j = 0; j < n_words; j++) begin
        logic [31:0] ew;
        ew = {rx_buf[4*j], rx_buf[4*j+1], rx_buf[4*j+2], rx_buf[4*j+3]};
        check(bmem[(idx0 + j) % 1024] == ew, "R6 packed word", bmem[(idx0 + j) % 1024], ew);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) bmem[i] = $urandom;
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_valid && !tx_valid && !rx_ready, "R1 reset state",
          {busy, done, mem_valid, tx_valid, rx_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done, "R1 after reset", {busy, done}, 0);

    // R2: immediate mode start has no effect
    acc_cnt = 0;
    dma_mode = 1'b0; dir = 2'b01; xfer_len = 24'h40; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!busy && !done, "R2 immediate mode ignored", {busy, done}, 0);
    repeat (5) @(negedge clk);
    check(acc_cnt == 0 && !busy, "R2 no access in immediate mode", acc_cnt, 0);

    // R8: rejected directions and zero masked length
    run_xfer(2'b10, 32'h100, 24'h40, 1'b0);
    run_xfer(2'b11, 32'h100, 24'h40, 1'b0);
    run_xfer(2'b01, 32'h100, 24'h1F, 1'b0);

    // R3 R5: unaligned base, memory to serial
    run_xfer(2'b01, 32'h105, 24'h40, 1'b0);
    // R6 R11: serial to memory with low length bits set and start pokes
    run_xfer(2'b00, 32'h21C, 24'h3F, 1'b1);
    run_xfer(2'b01, 32'h300, 24'h20, 1'b1);

    for (int i = 0; i < 14; i++) begin
      logic [1:0] d;
      d = 2'($urandom % 2);
      run_xfer(d, $urandom % 2048, 24'($urandom % 160), 1'($urandom % 2));
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule